// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a multicycle processor datapath that shares one memory, one ALU and a set of holding registers (instruction register, memory data register, operand registers A and B, and an ALU result register) across the cycles of each instruction. It is a Moore state machine. It reads the 6-bit opcode from the instruction register and steps through a fixed sequence of states for each instruction class. Every datapath control line is a function of the current state only.

Every instruction begins with the same two states. The first fetches the instruction and advances the PC by four. The second reads both source registers and, ahead of knowing the instruction type, computes the branch target into the ALU result register. From there, branches and jumps finish in a third cycle, stores and register-to-register operations in a fourth, and loads in a fifth. An opcode outside the supported set goes straight back to fetch after the decode state and writes nothing.

The conditional PC write for a branch is issued as a separate enable. The datapath combines it with its own zero flag.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) places the machine in the fetch state. Fetch drives ir_wr=1, mem_rd=1, pc_wr=1, mem_addr_sel=0 (address from PC), alu_a_sel=0 (PC), alu_b_sel=01 (constant 4), alu_op=00 and pc_src=00 (ALU result). All other outputs are 0.
- R2: The cycle after fetch is always decode. Decode drives alu_a_sel=0, alu_b_sel=11 (sign-extended offset shifted left by two) and alu_op=00. No write enable or memory strobe is asserted in decode.
- R3: A load (opcode 0x23) takes 5 cycles. The third is address calculation (alu_a_sel=1 for register A, alu_b_sel=10 for the sign-extended offset, alu_op=00). The fourth is a memory read with mem_rd=1 and mem_addr_sel=1 (address from the ALU result register). The fifth is a register write with rf_wr=1, rf_dst_rd=0 (rt field) and wb_from_mem=1.
- R4: A store (opcode 0x2B) takes 4 cycles. The third is the same address calculation as a load. The fourth drives mem_wr=1 and mem_addr_sel=1.
- R5: An R-type instruction (opcode 0x00) takes 4 cycles. The third drives alu_a_sel=1, alu_b_sel=00 (register B) and alu_op=10. The fourth drives rf_wr=1, rf_dst_rd=1 (rd field) and wb_from_mem=0.
- R6: A branch (opcode 0x04) takes 3 cycles. The third drives pc_wr_cond=1, pc_wr=0, pc_src=01 (ALU result register), alu_a_sel=1, alu_b_sel=00 and alu_op=01.
- R7: A jump (opcode 0x02) takes 3 cycles. The third drives pc_wr=1 and pc_src=10 (concatenated jump target).
- R8: Any other opcode returns to fetch in the cycle after decode and asserts no write enable or memory strobe on the way.
- R9: mem_rd and mem_wr are never high in the same cycle.
- R10: The outputs depend only on the state. A change of opcode within a cycle leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the datapath zero flag |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Write-back data: 0 ALU result register, 1 memory data register |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_rd | output | 1 | Destination field: 0 rt, 1 rd |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 B, 01 four, 10 offset, 11 offset shifted by two |
| alu_op | output | 2 | 00 add, 01 subtract, 10 use function field |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |

## Verification
The hardest situation to reach from the ports is the load write-back state, which comes only after four earlier states with a matching opcode. Next to it is a reset that lands in the middle of an instruction. The stimulus holds the load opcode for the whole sequence and checks every state on the way. It then starts a second load and raises reset during its memory read state, which shows that reset wins over the sequence. Moore behaviour is tested by changing the opcode in the middle of the R-type execute cycle and sampling the outputs again before the next edge.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OPC_W = 6;
  localparam int SEL_W = 2;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OP_JUMP  = 6'h02;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_MADDR, S_MREAD, S_LDWB,
    S_MWRITE, S_REXEC, S_RWB, S_BRANCH, S_JUMP
  } state_e;

  typedef struct packed {
    logic             pc_wr;
    logic             pc_wr_cond;
    logic             mem_addr_sel;
    logic             mem_rd;
    logic             mem_wr;
    logic             ir_wr;
    logic             wb_from_mem;
    logic             rf_wr;
    logic             rf_dst_rd;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic [SEL_W-1:0] alu_op;
    logic [SEL_W-1:0] pc_src;
  } ctrl_t;

  // State entered after decode for a given opcode
  function automatic state_e f_dispatch(input logic [OPC_W-1:0] opc);
    case (opc)
      OP_LOAD, OP_STORE: return S_MADDR;
      OP_RTYPE:          return S_REXEC;
      OP_BEQ:            return S_BRANCH;
      OP_JUMP:           return S_JUMP;
      default:           return S_FETCH;
    endcase
  endfunction

  function automatic logic f_known(input logic [OPC_W-1:0] opc);
    return (opc == OP_LOAD) || (opc == OP_STORE) || (opc == OP_RTYPE) ||
           (opc == OP_BEQ)  || (opc == OP_JUMP);
  endfunction

endpackage

// File: rtl/mc_state_reg.sv
module mc_state_reg
  import mc_ctrl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_e st_d,
  output state_e st_q
);

  always_ff @(posedge clk) begin
    if (rst) st_q <= S_FETCH;
    else     st_q <= st_d;
  end

  AST_RST_FETCH: assert property (@(posedge clk) rst |=> (st_q == S_FETCH)); // R1

endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  state_e           st_q,
  input  logic [OPC_W-1:0] opcode,
  output state_e           st_d
);

  logic dec_unknown;
  logic addr_is_load;

  assign dec_unknown  = !f_known(opcode);
  assign addr_is_load = (opcode == OP_LOAD);

  always_comb begin
    case (st_q)
      S_FETCH:  st_d = S_DECODE;
      S_DECODE: st_d = f_dispatch(opcode);
      S_MADDR:  st_d = addr_is_load ? S_MREAD : S_MWRITE;
      S_MREAD:  st_d = S_LDWB;
      S_REXEC:  st_d = S_RWB;
      default:  st_d = S_FETCH;
    endcase
  end

  AST_UNKNOWN_BACK: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_DECODE && dec_unknown) |=> (st_q == S_FETCH)); // R8
  AST_REXEC_TO_WB: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_REXEC) |=> (st_q == S_RWB)); // R5

endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
  import mc_ctrl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_e st_q,
  output ctrl_t  ctl
);

  always_comb begin
    ctl = '0;
    case (st_q)
      S_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_wr     = 1'b1;
        ctl.pc_wr     = 1'b1;
        ctl.alu_b_sel = 2'b01;
      end
      S_DECODE: ctl.alu_b_sel = 2'b11;
      S_MADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = 2'b10;
      end
      S_MREAD: begin
        ctl.mem_rd       = 1'b1;
        ctl.mem_addr_sel = 1'b1;
      end
      S_LDWB: begin
        ctl.rf_wr       = 1'b1;
        ctl.wb_from_mem = 1'b1;
      end
      S_MWRITE: begin
        ctl.mem_wr       = 1'b1;
        ctl.mem_addr_sel = 1'b1;
      end
      S_REXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_op    = 2'b10;
      end
      S_RWB: begin
        ctl.rf_wr     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      S_BRANCH: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_op     = 2'b01;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = 2'b01;
      end
      S_JUMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = 2'b10;
      end
      default: ctl = '0;
    endcase
  end

  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ctl.mem_rd && ctl.mem_wr)); // R9

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output logic       pc_wr,
  output logic       pc_wr_cond,
  output logic       mem_addr_sel,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       ir_wr,
  output logic       wb_from_mem,
  output logic       rf_wr,
  output logic       rf_dst_rd,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_op,
  output logic [1:0] pc_src
);

  state_e st_q;
  state_e st_d;
  ctrl_t  ctl;

  mc_state_reg u_reg (.clk(clk), .rst(rst), .st_d(st_d), .st_q(st_q));
  mc_next_state u_nxt (.clk(clk), .rst(rst), .st_q(st_q), .opcode(opcode), .st_d(st_d));
  mc_out_decode u_dec (.clk(clk), .rst(rst), .st_q(st_q), .ctl(ctl));

  assign pc_wr        = ctl.pc_wr;
  assign pc_wr_cond   = ctl.pc_wr_cond;
  assign mem_addr_sel = ctl.mem_addr_sel;
  assign mem_rd       = ctl.mem_rd;
  assign mem_wr       = ctl.mem_wr;
  assign ir_wr        = ctl.ir_wr;
  assign wb_from_mem  = ctl.wb_from_mem;
  assign rf_wr        = ctl.rf_wr;
  assign rf_dst_rd    = ctl.rf_dst_rd;
  assign alu_a_sel    = ctl.alu_a_sel;
  assign alu_b_sel    = ctl.alu_b_sel;
  assign alu_op       = ctl.alu_op;
  assign pc_src       = ctl.pc_src;

  // Named events for the checks below
  logic ev_fetch, ev_ld_read, ev_ld_wb, ev_jump;
  assign ev_fetch   = ir_wr;
  assign ev_ld_read = mem_rd && mem_addr_sel;
  assign ev_ld_wb   = rf_wr && wb_from_mem;
  assign ev_jump    = pc_wr && (pc_src == 2'b10);

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
    ev_fetch |=> (alu_b_sel == 2'b11 && !pc_wr && !pc_wr_cond && !ir_wr &&
                  !rf_wr && !mem_wr && !mem_rd)); // R2
  AST_LOAD_READ_WB: assert property (@(posedge clk) disable iff (rst)
    ev_ld_read |=> ev_ld_wb); // R3
  AST_LOAD_WB_DONE: assert property (@(posedge clk) disable iff (rst)
    ev_ld_wb |=> ev_fetch); // R3
  AST_STORE_DONE: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ev_fetch); // R4
  AST_BRANCH_DONE: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |=> ev_fetch); // R6
  AST_JUMP_DONE: assert property (@(posedge clk) disable iff (rst)
    ev_jump |=> ev_fetch); // R7

endmodule

// File: tb/sim_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module sim_mc_ctrl_fsm;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic pc_wr, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_wr;
  logic wb_from_mem, rf_wr, rf_dst_rd, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mc_ctrl_fsm u0 (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .mem_addr_sel(mem_addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_from_mem(wb_from_mem),
    .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src)
  );

  // Expected output word, field order:
  // pcw pcc adr mrd mwr irw w2m rfw dst a | b[2] op[2] src[2]
  function automatic logic [15:0] mk(input logic pcw, pcc, adr, mrd, mwr, irw,
                                     w2m, rfw, dst, a,
                                     input logic [1:0] b, op, src);
    return {pcw, pcc, adr, mrd, mwr, irw, w2m, rfw, dst, a, b, op, src};
  endfunction

  logic [15:0] X_FETCH, X_DEC, X_ADDR, X_MRD, X_LDWB, X_MWR, X_REX, X_RWB, X_BR, X_JMP;
  initial begin
    X_FETCH = mk(1,0,0,1,0,1,0,0,0,0,2'b01,2'b00,2'b00);
    X_DEC   = mk(0,0,0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00);
    X_ADDR  = mk(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00);
    X_MRD   = mk(0,0,1,1,0,0,0,0,0,0,2'b00,2'b00,2'b00);
    X_LDWB  = mk(0,0,0,0,0,0,1,1,0,0,2'b00,2'b00,2'b00);
    X_MWR   = mk(0,0,1,0,1,0,0,0,0,0,2'b00,2'b00,2'b00);
    X_REX   = mk(0,0,0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00);
    X_RWB   = mk(0,0,0,0,0,0,0,1,1,0,2'b00,2'b00,2'b00);
    X_BR    = mk(0,1,0,0,0,0,0,0,0,1,2'b00,2'b01,2'b01);
    X_JMP   = mk(1,0,0,0,0,0,0,0,0,0,2'b00,2'b00,2'b10);
  end

  function automatic logic [15:0] got();
    return {pc_wr, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_wr, wb_from_mem,
            rf_wr, rf_dst_rd, alu_a_sel, alu_b_sel, alu_op, pc_src};
  endfunction

  task automatic chk(input logic [15:0] exp, input string req, input string what);
    checks++;
    if (got() !== exp) begin
      errors++;
      $display("FAIL %s %s: got=%04h expected=%04h", req, what, got(), exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    chk(X_FETCH, "R1", "reset state");
    rst = 1'b0;
  endtask

  task automatic t_load();
    opcode = 6'h23;
    chk(X_FETCH, "R1", "load fetch");
    tick(); chk(X_DEC,  "R2", "load decode");
    tick(); chk(X_ADDR, "R3", "load address");
    tick(); chk(X_MRD,  "R3", "load read");
    tick(); chk(X_LDWB, "R3", "load write-back");
    tick(); chk(X_FETCH,"R3", "load done");
  endtask

  task automatic t_store();
    opcode = 6'h2B;
    tick(); chk(X_DEC,  "R2", "store decode");
    tick(); chk(X_ADDR, "R4", "store address");
    tick(); chk(X_MWR,  "R4", "store write");
    tick(); chk(X_FETCH,"R4", "store done");
  endtask

  task automatic t_rtype_moore();
    opcode = 6'h00;
    tick(); chk(X_DEC, "R2", "rtype decode");
    tick(); chk(X_REX, "R5", "rtype execute");
    opcode = 6'h23;
    #1; chk(X_REX, "R10", "opcode change mid-cycle");
    opcode = 6'h00;
    tick(); chk(X_RWB, "R5", "rtype write-back");
    tick(); chk(X_FETCH, "R5", "rtype done");
  endtask

  task automatic t_branch();
    opcode = 6'h04;
    tick(); chk(X_DEC, "R2", "branch decode");
    tick(); chk(X_BR,  "R6", "branch compare");
    tick(); chk(X_FETCH, "R6", "branch done");
  endtask

  task automatic t_jump();
    opcode = 6'h02;
    tick(); chk(X_DEC, "R2", "jump decode");
    tick(); chk(X_JMP, "R7", "jump write");
    tick(); chk(X_FETCH, "R7", "jump done");
  endtask

  task automatic t_unknown(input logic [5:0] opc);
    opcode = opc;
    tick(); chk(X_DEC, "R8", "unknown decode, no writes");
    tick(); chk(X_FETCH, "R8", "unknown back to fetch");
  endtask

  task automatic t_reset_mid();
    opcode = 6'h23;
    tick(); tick(); tick();
    chk(X_MRD, "R3", "second load read");
    if (mem_rd && mem_wr) begin
      errors++;
      $display("FAIL R9 both strobes: got=1 expected=0");
    end
    checks++;
    rst = 1'b1;
    tick(); chk(X_FETCH, "R1", "reset in mid-load");
    rst = 1'b0;
    tick(); chk(X_DEC, "R2", "decode after reset");
    tick(); chk(X_ADDR, "R3", "restarted load address");
    tick(); tick(); tick(); chk(X_FETCH, "R3", "restarted load done");
  endtask

  initial begin
    #1;
    t_reset();
    t_load();
    t_store();
    t_rtype_moore();
    t_branch();
    t_jump();
    t_unknown(6'h3F);
    t_unknown(6'h05);
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: got=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule